// File: doc/BRIEF.md
# Serial Transfer Engine with FIFOs

This block sits behind a register unit and carries data words between two 8-entry queues. Software-side logic pushes words into a transmit queue and pops results from a receive queue. While the engine is enabled, it takes the oldest transmit word and sends it out as an SPI master, MSB first in SPI mode 0, with chip select held low for the whole frame. It captures the word returned on the input line and places it in the receive queue, masked to the programmed word width. In loopback mode the serial pins stay idle and the transmitted word itself is stored. Both queue occupancies are exported for the register unit's status and interrupt logic.

The engine never lets the receive queue overflow. A frame starts only when the receive queue has a free slot, so a full receive queue stalls transmission until a word is popped. The controller is a four-state machine. `ST_IDLE` waits for a start condition. `ST_LOW` holds the serial clock low and samples the input line when its half-period ends. `ST_HIGH` holds the clock high and either moves to the next bit or finishes. `ST_STORE` writes the captured word into the receive queue. The transitions are:

- IDLE→LOW when a frame starts in normal mode.
- IDLE→STORE when a frame starts in loopback mode.
- LOW→HIGH when a half-period expires.
- HIGH→LOW when a half-period expires and more bits remain.
- HIGH→STORE after the last bit.
- STORE→IDLE unconditionally.

Top module: `ste_core`

## Requirements
- R1: Each queue holds at most 8 words. A transmit push while the transmit queue holds 8 words is ignored, and a receive pop while the receive queue is empty is ignored.
- R2: While `enable` is low, no frame starts and queued transmit words stay in the transmit queue.
- R3: A frame starts only when the transmit queue is non-empty and the receive queue holds fewer than 8 words; otherwise the engine stalls.
- R4: Each frame removes exactly one transmit word when it starts and adds exactly one receive word when it ends, in first-in first-out order.
- R5: With `loopback` high at frame start, the stored word is the transmit word, `spi_cs_n` stays high and `spi_sck` stays low.
- R6: The effective word width is `size_sel`+1 bits, and a `size_sel` below 3 gives 4 bits. The stored word keeps only that many low bits; all higher bits are zero.
- R7: While `slave_sel` is high, the engine behaves as disabled and starts no frame, even with `enable` high.
- R8: In normal mode a frame drives `spi_cs_n` low throughout. `spi_mosi` carries the word MSB first, changing while `spi_sck` is low. `spi_miso` is sampled at each rising `spi_sck`. Each `spi_sck` half-period lasts `clk_div`+1 clock cycles.
- R9: `busy` is high from the cycle after a frame starts until the cycle its word is written into the receive queue, and low otherwise.
- R10: After reset both counts are 0, `busy` is low, `spi_cs_n` is high and `spi_sck` is low.
- R11: `rx_data` always shows the oldest word in the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows frames to start |
| loopback | input | 1 | Returns the transmit word internally |
| slave_sel | input | 1 | Unsupported slave selection; forces the engine idle |
| size_sel | input | 4 | Word width minus one |
| clk_div | input | 8 | Serial clock half-period minus one, in clock cycles |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| rx_pop | input | 1 | Remove the oldest receive word |
| rx_data | output | 16 | Oldest receive word |
| tx_count | output | 4 | Transmit queue occupancy, 0 to 8 |
| rx_count | output | 4 | Receive queue occupancy, 0 to 8 |
| busy | output | 1 | Frame in progress |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bound checker enforces several properties on every cycle:

- Both counts stay at or below 8.
- A transmit word leaves only while enabled, not in slave mode, and with room in the receive queue.
- A receive word arrives only from a frame in progress.
- Chip select falls only when loopback was low at frame start.
- The serial clock is high only inside a selected frame, which is itself always marked busy.

Only the bench scenarios can show the data itself:

- FIFO order across a stall.
- The width mask, including the clamp for small sizes.
- MSB-first bit order on the output line.
- Returned-word capture.
- The measured half-period length.

// File: rtl/ste_pkg.sv
package ste_pkg;
    localparam int FIFO_DEPTH = 8;
    localparam int WORD_W     = 16;
    localparam int MIN_W      = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STORE
    } eng_state_t;
endpackage

// File: rtl/ste_fifo.sv
module ste_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign push_ok = push && (count < CNT_W'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/ste_shift_engine.sv
module ste_shift_engine
    import ste_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DIV_W = 8,
    localparam int LW   = $clog2(DW + 1),
    localparam int SZ_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             loop_mode,
    input  logic [DW-1:0]    word_in,
    input  logic [SZ_W-1:0]  size_sel,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             miso,
    output logic             ready,
    output logic             store,
    output logic [DW-1:0]    word_out,
    output logic             busy,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi
);
    eng_state_t       state, nxt;
    logic [DIV_W-1:0] div_cnt;
    logic [LW-1:0]    bit_cnt;
    logic [DW-1:0]    tx_sh, rx_sh, mask_q;
    logic [LW-1:0]    eff_w;
    logic             half_done;

    assign eff_w     = (size_sel < SZ_W'(MIN_W - 1)) ? LW'(MIN_W) : LW'(size_sel) + LW'(1);
    assign half_done = (div_cnt == clk_div);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = loop_mode ? ST_STORE : ST_LOW;
            ST_LOW:   if (half_done) nxt = ST_HIGH;
            ST_HIGH:  if (half_done) nxt = (bit_cnt == '0) ? ST_STORE : ST_LOW;
            ST_STORE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    tx_sh   <= word_in << (LW'(DW) - eff_w);
                    rx_sh   <= loop_mode ? word_in : '0;
                    mask_q  <= {DW{1'b1}} >> (LW'(DW) - eff_w);
                    bit_cnt <= eff_w - LW'(1);
                    div_cnt <= '0;
                end
                ST_LOW: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        rx_sh   <= {rx_sh[DW-2:0], miso};
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        if (bit_cnt != '0) begin
                            bit_cnt <= bit_cnt - 1'b1;
                            tx_sh   <= tx_sh << 1;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_STORE: div_cnt <= '0;
                default:  div_cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready    = (state == ST_IDLE);
        busy     = (state != ST_IDLE);
        store    = (state == ST_STORE);
        cs_n     = !((state == ST_LOW) || (state == ST_HIGH));
        sck      = (state == ST_HIGH);
        mosi     = cs_n ? 1'b0 : tx_sh[DW-1];
        word_out = rx_sh & mask_q;
    end
endmodule

// File: rtl/ste_core.sv
module ste_core
    import ste_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = WORD_W,
    parameter int DIV_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SZ_W  = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             loopback,
    input  logic             slave_sel,
    input  logic [SZ_W-1:0]  size_sel,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_data,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             busy,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic          eng_ready, eng_store, start;
    logic [DW-1:0] tx_head, rx_word;

    assign start = eng_ready && enable && !slave_sel &&
                   (tx_count != '0) && (rx_count < CNT_W'(DEPTH));

    ste_fifo #(.DEPTH(DEPTH), .W(DW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_data),
        .pop(start), .rdata(tx_head), .count(tx_count)
    );

    ste_fifo #(.DEPTH(DEPTH), .W(DW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(eng_store), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data), .count(rx_count)
    );

    ste_shift_engine #(.DW(DW), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start), .loop_mode(loopback), .word_in(tx_head),
        .size_sel(size_sel), .clk_div(clk_div), .miso(spi_miso),
        .ready(eng_ready), .store(eng_store), .word_out(rx_word),
        .busy(busy), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
    );
endmodule

// File: rtl/ste_core_chk.sv
module ste_core_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             loopback,
    input logic             slave_sel,
    input logic             tx_push,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             busy,
    input logic             spi_cs_n,
    input logic             spi_sck
);
    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    // R3 R2 R7
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tx_push) && (tx_count == $past(tx_count) - 1'b1))
        |-> ($past(enable) && !$past(slave_sel) && ($past(rx_count) < CNT_W'(DEPTH))));

    // R4 R9
    rx_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == $past(rx_count) + 1'b1) |-> $past(busy));

    // R5
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !$past(loopback));

    // R8
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    // R9
    frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);
endmodule

bind ste_core ste_core_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_ste_core.sv
module tb_ste_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, loopback = 1'b0, slave_sel = 1'b0;
    logic [3:0]  size_sel = 4'd7;
    logic [7:0]  clk_div = 8'd1;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic [3:0]  tx_count, rx_count;
    logic        busy, spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench-side slave model
    int          frame_no = 0;
    int          cur_w = 8;
    int          bidx;
    logic [15:0] resp_w, mosi_sh;
    logic [15:0] cap_q[$];

    always #10 clk = ~clk;

    ste_core dut (.*);

    function automatic logic [15:0] resp_fn(int n);
        return 16'hA5C3 ^ 16'(n * 16'h3B1);
    endfunction

    function automatic int width_of(logic [3:0] s);
        return (s < 4'd3) ? 4 : int'(s) + 1;
    endfunction

    function automatic logic [15:0] mask_of(int w);
        return 16'((32'h1 << w) - 1);
    endfunction

    always @(negedge spi_cs_n) begin
        resp_w   = resp_fn(frame_no);
        bidx     = cur_w - 1;
        spi_miso = resp_w[bidx];
        mosi_sh  = '0;
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n && bidx > 0) begin
            bidx     = bidx - 1;
            spi_miso = resp_w[bidx];
        end
    end
    always @(posedge spi_sck) mosi_sh = {mosi_sh[14:0], spi_mosi};
    always @(posedge spi_cs_n) if (rst_n) begin
        cap_q.push_back(mosi_sh);
        frame_no = frame_no + 1;
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FIFO-engine FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [15:0] v);
        tx_data = v;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_expect(logic [15:0] exp, string tag);
        int n = 0;
        while (rx_count == 0 && n < 2000) begin @(negedge clk); n++; end
        check(rx_data == exp, tag, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((tx_count != 0 || busy) && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic run_normal(int nw, logic [3:0] sz, logic [7:0] dv);
        logic [15:0] words[8];
        int base;
        int w;
        size_sel = sz; clk_div = dv; loopback = 1'b0; enable = 1'b1;
        w = width_of(sz); cur_w = w;
        base = frame_no;
        cap_q.delete();
        for (int i = 0; i < nw; i++) begin
            words[i] = 16'($urandom);
            push(words[i]);
        end
        wait_idle();
        for (int i = 0; i < nw; i++) begin
            // R8: MOSI carries the word MSB first
            check(cap_q.size() > i && cap_q[i] == (words[i] & mask_of(w)), "R8 mosi",
                  cap_q.size() > i ? cap_q[i] : 16'hDEAD, words[i] & mask_of(w));
        end
        for (int i = 0; i < nw; i++)
            pop_expect(resp_fn(base + i) & mask_of(w), "R8 R6 miso capture");
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; fails++;
            $display("FIFO-engine FAIL watchdog: actual %0d expected done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a[8], b[8];
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(tx_count == 0 && rx_count == 0, "R10 counts", {tx_count, rx_count}, 0);
        check(!busy && spi_cs_n && !spi_sck, "R10 lines", {busy, spi_cs_n, spi_sck}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, words stay queued
        loopback = 1'b1; size_sel = 4'd7;
        for (int i = 0; i < 3; i++) push(16'h1230 + 16'(i));
        repeat (20) @(negedge clk);
        check(tx_count == 3 && rx_count == 0, "R2 disabled hold", {tx_count, rx_count}, 8'h30);

        // R7: slave selection keeps engine idle
        slave_sel = 1'b1; enable = 1'b1;
        repeat (20) @(negedge clk);
        check(tx_count == 3 && !busy, "R7 slave idle", {tx_count, busy}, 5'h6);
        slave_sel = 1'b0;

        // R5 R6 R11: loopback returns masked words in order
        @(negedge clk);
        check(spi_cs_n && !spi_sck, "R5 lines idle", {spi_cs_n, spi_sck}, 2'b10);
        wait_idle();
        for (int i = 0; i < 3; i++) pop_expect((16'h1230 + 16'(i)) & 16'h00FF, "R5 R6 R11 loop data");

        // R3 R1 R4: stall with full receive queue
        enable = 1'b0;
        for (int i = 0; i < 8; i++) begin a[i] = 16'($urandom); push(a[i]); end
        enable = 1'b1;
        wait_idle();
        for (int i = 0; i < 8; i++) begin b[i] = 16'($urandom); push(b[i]); end
        repeat (30) @(negedge clk);
        check(tx_count == 8 && rx_count == 8, "R3 stall", {tx_count, rx_count}, 8'h88);
        push(16'hFFFF);
        check(tx_count == 8, "R1 push full ignored", tx_count, 8);
        pop_expect(a[0] & 16'h00FF, "R4 order a0");
        repeat (6) @(negedge clk);
        check(tx_count == 7 && rx_count == 8, "R4 one per frame", {tx_count, rx_count}, 8'h78);
        for (int i = 1; i < 8; i++) pop_expect(a[i] & 16'h00FF, "R4 order a");
        for (int i = 0; i < 8; i++) pop_expect(b[i] & 16'h00FF, "R4 order b");
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        check(rx_count == 0, "R1 pop empty ignored", rx_count, 0);

        // R6: small size clamps to 4 bits
        size_sel = 4'd1;
        push(16'hBEEF);
        pop_expect(16'h000F, "R6 clamp to 4");

        // R8 R9: normal mode, timing and busy
        run_normal(3, 4'd15, 8'd1);
        run_normal(2, 4'd2, 8'd0);
        clk_div = 8'd2; size_sel = 4'd7; cur_w = 8; loopback = 1'b0;
        push(16'h00A5);
        while (spi_cs_n) @(negedge clk);
        check(busy, "R9 busy in frame", busy, 1);
        while (!spi_sck) @(negedge clk);
        begin
            int hp = 0;
            while (spi_sck) begin @(negedge clk); hp++; end
            check(hp == 3, "R8 half period", hp, 3);
        end
        while (rx_count == 0) @(negedge clk);
        check(!busy, "R9 busy clears on store", busy, 0);
        pop_expect(resp_fn(frame_no - 1) & 16'h00FF, "R8 single frame");

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [15:0] q[$];
            logic [3:0] sz = 4'($urandom_range(0, 15));
            int n = $urandom_range(1, 8);
            if (it % 5 == 0) run_normal(n, sz, 8'($urandom_range(0, 2)));
            else begin
                loopback = 1'b1; size_sel = sz;
                for (int i = 0; i < n; i++) begin
                    logic [15:0] v = 16'($urandom);
                    q.push_back(v & mask_of(width_of(sz)));
                    push(v);
                end
                for (int i = 0; i < n; i++) pop_expect(q[i], "R4 R6 random loop");
            end
            wait_idle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule